// File: doc/BRIEF.md
# Twelve-Pin GPIO Port with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O port of twelve pins. Each pin can be driven from an output data register or left as an input. The level of each input is brought into the clock domain by two flip-flops. From there it is readable by the host and feeds a per-pin trigger detector. Each pin's trigger can be set to fire on a rising edge, a falling edge, either edge, a high level or a low level.

A detected trigger sets the pin's pending bit only while the pin's enable bit is set. A pending bit stays set until the host writes a one to clear it. A mask register is set and cleared through two separate write-one registers. The single active-high interrupt output is raised whenever any pin is both pending and unmasked. Writing a one and then a zero to the soft-reset register puts every register back to its reset value.

The host reaches all of this through a simple 32-bit register bus. A register is selected by its byte offset. Reads are combinational, and writes take effect at the clock edge.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads zero except the mask register (read at offset 0x10), which reads 0xFFF. The interrupt output is low and no pin is driven (pin_oe all zero).
- R2: The direction register (offset 0x20) sets pin_oe bit for bit, where 1 means output. The output data register (offset 0x18) sets pin_out. Both read back what was written.
- R3: The input register (offset 0x1C) returns pin_in through two flip-flops. A pin change that is set up before clock edge k is still not visible after edge k, and is visible after edge k+1.
- R4: Each pin's trigger code sits in bits [4s+2:4s] of a mode register: pins 0-7 in the register at 0x24 with s equal to the pin index, and pins 8-11 in the register at 0x28 with s equal to the pin index minus 8. The codes are 0 falling edge, 1 rising edge, 2 low level, 3 high level and 4 both edges. Writing all ones reads back 0x77777777 at 0x24 and 0x00007777 at 0x28.
- R5: A trigger on a pin whose bit in the enable register (offset 0x00) is 0 never sets that pin's pending bit.
- R6: The status register (offset 0x04) shows one pending bit per pin. Writing 1 to a bit of the clear register (offset 0x0C) clears that pin's pending bit, and 0 bits leave their pins alone. In a level mode the bit sets again on the very next cycle while the level is still present, so a clear has no lasting effect.
- R7: Writing 1 to a bit at offset 0x10 masks that pin, and writing 1 at offset 0x14 unmasks it. Zero bits change nothing in either register. The display register (offset 0x08) reads status AND NOT mask.
- R8: The interrupt output is high exactly when some pin is both pending and unmasked.
- R9: Writing 1 to bit 0 of the soft-reset register (offset 0x3C) changes no other register, and the register reads back 1. A following write with bit 0 at 0 returns every register to its R1 state.
- R10: Bits above pin 11 in per-pin registers read 0. The use-select register (offset 0x38) is plain storage. Trigger codes 5 to 7 never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 12 | Pad input levels, asynchronous |
| pin_out | output | 12 | Output data for the pads |
| pin_oe | output | 12 | Pad output enables |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest situation to reach is a level-mode pin whose pending bit is cleared while the level is still held. In that cycle, the clear and a fresh detection land on the same clock edge, and the detection must win. The stimulus holds a pin high in high-level mode, writes its clear bit, and reads status back right away. It then drops the level and clears again to show that the bit really goes away. A second hard case is a clear and an unmask written to neighbouring pins while another pin stays pending. The stimulus builds that state with two enabled edge pins and one disabled pin, each raised at the same moment.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned BUS_W   = 32;
    localparam int unsigned ADDR_W  = 6;
    localparam int unsigned CODE_W  = 3;
    localparam int unsigned SLOT_W  = 4;
    localparam int unsigned SLOTS_PER_REG = BUS_W / SLOT_W;

    // Trigger selection codes per pin
    typedef enum logic [CODE_W-1:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

    // Word index of each register (byte offset / 4)
    typedef enum logic [3:0] {
        RI_ENABLE  = 4'd0,
        RI_PENDING = 4'd1,
        RI_VISIBLE = 4'd2,
        RI_ACK     = 4'd3,
        RI_MSET    = 4'd4,
        RI_MCLR    = 4'd5,
        RI_DOUT    = 4'd6,
        RI_DIN     = 4'd7,
        RI_DIR     = 4'd8,
        RI_TRIG_LO = 4'd9,
        RI_TRIG_HI = 4'd10,
        RI_SPARE   = 4'd14,
        RI_SWRST   = 4'd15
    } reg_idx_e;

    // One bus transfer, already decoded to word granularity
    typedef struct packed {
        logic             wr;
        logic [3:0]       idx;
        logic [BUS_W-1:0] data;
    } bus_xfer_t;

    // Does the current / previous level pair fire for this code?
    function automatic logic trig_fires(logic [CODE_W-1:0] code, logic cur, logic prev);
        logic fire;
        case (code)
            TRIG_FALL: fire = prev & ~cur;
            TRIG_RISE: fire = cur & ~prev;
            TRIG_LOW:  fire = ~cur;
            TRIG_HIGH: fire = cur;
            TRIG_BOTH: fire = cur ^ prev;
            default:   fire = 1'b0;
        endcase
        return fire;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPINS-1:0]        level,
    input  logic [NPINS*CODE_W-1:0] codes,
    output logic [NPINS-1:0]        fire
);
    logic [NPINS-1:0] level_d;

    always_ff @(posedge clk) begin
        if (rst) level_d <= '0;
        else     level_d <= level;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign fire[p] = trig_fires(codes[p*CODE_W +: CODE_W], level[p], level_d[p]);
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  bus_xfer_t               xfer,
    input  logic [3:0]              rd_idx,
    input  logic                    rd_en,
    input  logic [NPINS-1:0]        din,
    input  logic [NPINS-1:0]        fire,
    output logic [BUS_W-1:0]        rdata,
    output logic [NPINS-1:0]        ien_q,
    output logic [NPINS-1:0]        pend_q,
    output logic [NPINS-1:0]        mask_q,
    output logic [NPINS-1:0]        dout_q,
    output logic [NPINS-1:0]        dir_q,
    output logic [NPINS*CODE_W-1:0] codes,
    output logic                    arm_q
);
    localparam int unsigned PAD = BUS_W - NPINS;

    logic [CODE_W-1:0] code_q [NPINS];
    logic [NPINS-1:0]  spare_q;
    logic [NPINS-1:0]  ack_bits;
    logic              soft_clear;
    logic [BUS_W-1:0]  trig_lo_rd;
    logic [BUS_W-1:0]  trig_hi_rd;

    assign ack_bits   = (xfer.wr && xfer.idx == RI_ACK) ? xfer.data[NPINS-1:0] : '0;
    assign soft_clear = xfer.wr && xfer.idx == RI_SWRST && !xfer.data[0] && arm_q;

    always_ff @(posedge clk) begin
        if (rst || soft_clear) begin
            ien_q   <= '0;
            pend_q  <= '0;
            mask_q  <= '1;
            dout_q  <= '0;
            dir_q   <= '0;
            spare_q <= '0;
            arm_q   <= 1'b0;
            for (int p = 0; p < NPINS; p++) code_q[p] <= '0;
        end else begin
            // a fresh detection wins over a clear in the same cycle
            pend_q <= (pend_q & ~ack_bits) | (fire & ien_q);
            if (xfer.wr) begin
                case (xfer.idx)
                    RI_ENABLE: ien_q   <= xfer.data[NPINS-1:0];
                    RI_MSET:   mask_q  <= mask_q | xfer.data[NPINS-1:0];
                    RI_MCLR:   mask_q  <= mask_q & ~xfer.data[NPINS-1:0];
                    RI_DOUT:   dout_q  <= xfer.data[NPINS-1:0];
                    RI_DIR:    dir_q   <= xfer.data[NPINS-1:0];
                    RI_SPARE:  spare_q <= xfer.data[NPINS-1:0];
                    RI_SWRST:  arm_q   <= xfer.data[0];
                    default: ;
                endcase
                for (int p = 0; p < NPINS; p++) begin
                    if ((p < SLOTS_PER_REG && xfer.idx == RI_TRIG_LO) ||
                        (p >= SLOTS_PER_REG && xfer.idx == RI_TRIG_HI))
                        code_q[p] <= xfer.data[(p % SLOTS_PER_REG)*SLOT_W +: CODE_W];
                end
            end
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_codes
        assign codes[p*CODE_W +: CODE_W] = code_q[p];
    end

    always_comb begin
        trig_lo_rd = '0;
        trig_hi_rd = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (p < SLOTS_PER_REG)
                trig_lo_rd[(p % SLOTS_PER_REG)*SLOT_W +: CODE_W] = code_q[p];
            else
                trig_hi_rd[(p % SLOTS_PER_REG)*SLOT_W +: CODE_W] = code_q[p];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (rd_idx)
                RI_ENABLE:  rdata = {{PAD{1'b0}}, ien_q};
                RI_PENDING: rdata = {{PAD{1'b0}}, pend_q};
                RI_VISIBLE: rdata = {{PAD{1'b0}}, pend_q & ~mask_q};
                RI_MSET:    rdata = {{PAD{1'b0}}, mask_q};
                RI_DOUT:    rdata = {{PAD{1'b0}}, dout_q};
                RI_DIN:     rdata = {{PAD{1'b0}}, din};
                RI_DIR:     rdata = {{PAD{1'b0}}, dir_q};
                RI_TRIG_LO: rdata = trig_lo_rd;
                RI_TRIG_HI: rdata = trig_hi_rd;
                RI_SPARE:   rdata = {{PAD{1'b0}}, spare_q};
                RI_SWRST:   rdata = {{(BUS_W-1){1'b0}}, arm_q};
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0]        din_sync;
    logic [NPINS-1:0]        fire;
    logic [NPINS*CODE_W-1:0] codes;
    logic [NPINS-1:0]        ien_w;
    logic [NPINS-1:0]        pend_w;
    logic [NPINS-1:0]        mask_w;
    logic                    arm_w;
    logic                    aligned;
    bus_xfer_t               xfer;

    assign aligned   = bus_sel && bus_addr[1:0] == 2'b00;
    assign xfer.wr   = aligned && bus_we;
    assign xfer.idx  = bus_addr[5:2];
    assign xfer.data = bus_wdata;

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (din_sync)
    );

    gpio_trig_detect #(.NPINS(NPINS)) u_detect (
        .clk   (clk),
        .rst   (rst),
        .level (din_sync),
        .codes (codes),
        .fire  (fire)
    );

    gpio_regfile #(.NPINS(NPINS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .xfer   (xfer),
        .rd_idx (bus_addr[5:2]),
        .rd_en  (aligned && !bus_we),
        .din    (din_sync),
        .fire   (fire),
        .rdata  (bus_rdata),
        .ien_q  (ien_w),
        .pend_q (pend_w),
        .mask_q (mask_w),
        .dout_q (pin_out),
        .dir_q  (pin_oe),
        .codes  (codes),
        .arm_q  (arm_w)
    );

    assign irq = |(pend_w & ~mask_w);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int unsigned NPINS = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [5:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [NPINS-1:0] pin_out,
    input logic             irq,
    input logic [NPINS-1:0] ien,
    input logic [NPINS-1:0] pend,
    input logic [NPINS-1:0] mask,
    input logic             arm
);
    logic wr_any;
    assign wr_any = bus_sel && bus_we && bus_addr[1:0] == 2'b00;

    // R7: mask-set write leaves every written-one bit masked
    a_r7_mask_set: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr[5:2] == 4'd4) |=>
            ((mask & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    // R7: mask-clear write leaves every written-one bit unmasked
    a_r7_mask_clr: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr[5:2] == 4'd5) |=>
            ((mask & $past(bus_wdata[NPINS-1:0])) == '0));

    // R5: no pending bit rises on a pin that was disabled
    a_r5_enable_gate: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & ~$past(ien) & ~$past(pend)) == '0));

    // R8: fully masked port never requests
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (&mask) |-> !irq);

    // R2: output data holds unless written or soft-reset
    a_r2_dout_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_any && (bus_addr[5:2] == 4'd6 || bus_addr[5:2] == 4'd15)) |=> $stable(pin_out));

    // R9: the second write of the soft-reset pair restores reset values
    a_r9_soft_reset: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr[5:2] == 4'd15 && !bus_wdata[0] && arm) |=>
            ((&mask) && pend == '0 && ien == '0 && !arm && !irq));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .irq       (irq),
    .ien       (ien_w),
    .pend      (pend_w),
    .mask      (mask_w),
    .arm       (arm_w)
);

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;
    localparam int N = 12;
    localparam logic [5:0] A_EN = 6'h00, A_PEND = 6'h04, A_VIS = 6'h08, A_ACK = 6'h0C,
                           A_MSET = 6'h10, A_MCLR = 6'h14, A_DOUT = 6'h18, A_DIN = 6'h1C,
                           A_DIR = 6'h20, A_TLO = 6'h24, A_THI = 6'h28, A_SPARE = 6'h38,
                           A_SRST = 6'h3C;

    // {code, start level, end level, expected pending} for pin 3
    localparam int NV = 12;
    localparam logic [5:0] VEC [NV] = '{
        {3'd0, 1'b1, 1'b0, 1'b1}, {3'd0, 1'b0, 1'b1, 1'b0},
        {3'd1, 1'b0, 1'b1, 1'b1}, {3'd1, 1'b1, 1'b0, 1'b0},
        {3'd2, 1'b1, 1'b0, 1'b1}, {3'd2, 1'b1, 1'b1, 1'b0},
        {3'd3, 1'b0, 1'b1, 1'b1}, {3'd3, 1'b0, 1'b0, 1'b0},
        {3'd4, 1'b0, 1'b1, 1'b1}, {3'd4, 1'b1, 1'b0, 1'b1},
        {3'd5, 1'b0, 1'b1, 1'b0}, {3'd7, 1'b1, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out;
    logic [N-1:0] pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    gpio_irq_port #(.NPINS(N)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_EN, rv);   check("R1 enable", rv, 32'h0);
        rd(A_PEND, rv); check("R1 pending", rv, 32'h0);
        rd(A_MSET, rv); check("R1 mask", rv, 32'hFFF);
        rd(A_DIR, rv);  check("R1 dir", rv, 32'h0);
        rd(A_TLO, rv);  check("R1 mode lo", rv, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pin_oe", {20'b0, pin_oe}, 32'h0);

        // R2 direction and output data; R10 upper bits
        wr(A_DIR, 32'hFFFF_F0A5);
        wr(A_DOUT, 32'h0000_00F0);
        check("R2 pin_oe", {20'b0, pin_oe}, 32'h0A5);
        check("R2 pin_out", {20'b0, pin_out}, 32'h0F0);
        rd(A_DIR, rv);  check("R10 dir upper bits", rv, 32'h0A5);
        rd(A_DOUT, rv); check("R2 dout readback", rv, 32'h0F0);
        wr(A_SPARE, 32'hFFFF_FABC);
        rd(A_SPARE, rv); check("R10 spare storage", rv, 32'hABC);

        // R3 two-flop input path
        @(negedge clk); pin_in = 12'h5A3;
        @(posedge clk); #1; // edge k
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_DIN; #0.2;
        check("R3 not after one edge", bus_rdata, 32'h0);
        @(posedge clk); #1; // edge k+1
        check("R3 visible after two edges", bus_rdata, 32'h5A3);
        bus_sel = 1'b0;
        @(negedge clk); pin_in = '0;
        settle();

        // R4 slot layout readback
        wr(A_TLO, 32'hFFFF_FFFF); rd(A_TLO, rv); check("R4 mode lo fields", rv, 32'h7777_7777);
        wr(A_THI, 32'hFFFF_FFFF); rd(A_THI, rv); check("R4 mode hi fields", rv, 32'h0000_7777);
        wr(A_TLO, 32'h0); wr(A_THI, 32'h0);

        // R4/R10 trigger table on pin 3 (slot bits 14:12 of low mode register)
        for (int i = 0; i < NV; i++) begin
            wr(A_EN, 32'h0);
            @(negedge clk); pin_in[3] = VEC[i][2];
            settle();
            wr(A_TLO, {17'b0, VEC[i][5:3], 12'b0});
            wr(A_ACK, 32'hFFF);
            wr(A_EN, 32'h008);
            wr(A_MCLR, 32'h008);
            @(negedge clk); pin_in[3] = VEC[i][1];
            settle();
            rd(A_PEND, rv);
            check($sformatf("R4 code %0d pend", VEC[i][5:3]), {31'b0, rv[3]}, {31'b0, VEC[i][0]});
            check($sformatf("R8 code %0d irq", VEC[i][5:3]), {31'b0, irq}, {31'b0, VEC[i][0]});
            wr(A_EN, 32'h0);
            wr(A_MSET, 32'hFFF);
            wr(A_ACK, 32'hFFF);
        end
        @(negedge clk); pin_in = '0;
        settle();

        // R6 level re-set after clear: pin 5 high level (bits 22:20)
        wr(A_TLO, 32'h0030_0000);
        wr(A_EN, 32'h020);
        @(negedge clk); pin_in[5] = 1'b1;
        settle();
        wr(A_ACK, 32'h020);
        rd(A_PEND, rv); check("R6 level sets again after clear", rv, 32'h020);
        @(negedge clk); pin_in[5] = 1'b0;
        settle();
        wr(A_ACK, 32'h020);
        rd(A_PEND, rv); check("R6 clear after level gone", rv, 32'h0);

        // R5 enable gating, R6 partial clear: pins 0,1 rising (low reg), pin 10 rising (high reg bits 10:8)
        wr(A_TLO, 32'h0000_0011);
        wr(A_THI, 32'h0000_0100);
        wr(A_EN, 32'h401);
        @(negedge clk); pin_in = 12'h403;
        settle();
        rd(A_PEND, rv); check("R5 disabled pin stays idle", rv, 32'h401);
        wr(A_ACK, 32'h001);
        rd(A_PEND, rv); check("R6 zero bits keep pending", rv, 32'h400);

        // R7/R8 masking and display
        check("R8 masked pending gives no irq", {31'b0, irq}, 32'h0);
        rd(A_VIS, rv); check("R7 display all masked", rv, 32'h0);
        wr(A_MCLR, 32'h400);
        rd(A_VIS, rv); check("R7 display unmasked", rv, 32'h400);
        check("R8 irq raised", {31'b0, irq}, 32'h1);
        wr(A_MSET, 32'h0);
        rd(A_MSET, rv); check("R7 zero set bits no effect", rv, 32'hBFF);
        wr(A_MSET, 32'h400);
        check("R8 irq dropped by mask", {31'b0, irq}, 32'h0);
        rd(A_MSET, rv); check("R7 mask restored", rv, 32'hFFF);
        wr(A_MCLR, 32'h0);
        rd(A_MSET, rv); check("R7 zero clear bits no effect", rv, 32'hFFF);
        wr(A_MCLR, 32'h400);

        // R9 soft reset pair
        wr(A_SRST, 32'h1);
        rd(A_DIR, rv);  check("R9 arm alone keeps dir", rv, 32'h0A5);
        rd(A_SRST, rv); check("R9 arm readback", rv, 32'h1);
        check("R9 irq before reset", {31'b0, irq}, 32'h1);
        wr(A_SRST, 32'h0);
        rd(A_DIR, rv);  check("R9 dir cleared", rv, 32'h0);
        rd(A_MSET, rv); check("R9 mask all ones", rv, 32'hFFF);
        rd(A_PEND, rv); check("R9 pending cleared", rv, 32'h0);
        rd(A_EN, rv);   check("R9 enable cleared", rv, 32'h0);
        rd(A_THI, rv);  check("R9 mode hi cleared", rv, 32'h0);
        check("R9 irq low", {31'b0, irq}, 32'h0);
        check("R9 pin_out low", {20'b0, pin_out}, 32'h0);

        finish_run();
    end
endmodule